// File: doc/BRIEF.md
# Five-to-Eight Lane Sample Gearbox

This block repacks a parallel sample stream. Upstream logic hands it a word of five samples per clock together with a valid flag. Downstream sits a wide-input transform engine that takes a power-of-two count of samples per cycle, here eight. The gearbox appends each accepted five-sample word behind whatever it still holds. Whenever at least eight samples are on hand, it sends the oldest eight out as one word, raises the output valid for that cycle and keeps the rest for later.

The lane counts do not divide evenly, so the output valid does not follow a plain divider. It follows an on/off cadence set by the number of samples left over. With continuous input from empty, the leftover count after each cycle runs 5, 2, 7, 4, 1, 6, 3, 0. Eight input words (forty samples) yield exactly five output words and bring the leftover count back to zero. Samples leave in exactly the order they arrived, across any word boundary and across idle gaps.

Top module: `lane_gearbox`

## Requirements
- R1: While rst_ni is low, valid_o is low and data_o is zero. After reset is released the buffer holds no samples, so the first accepted word does not produce an output.
- R2: A cycle with valid_i high adds exactly five samples. If the number of held samples plus five is eight or more, the next cycle shows valid_o high with eight samples on data_o.
- R3: If the number of samples on hand after accepting the cycle's input is below eight, valid_o is low in the next cycle.
- R4: Sample order is preserved. Input lane k sits at data_i bits [16k+15:16k] and lane 0 is the earliest sample of its word. Output lane k sits at data_o bits [16k+15:16k], with lane 0 the oldest and lane 7 the newest. Leftover samples lead the next output word.
- R5: From empty with valid_i held high, valid_o runs low, high, low, high, high, low, high, high over each period of eight input cycles. This follows from the leftover counts 5, 2, 7, 4, 1, 6, 3, 0. Every such period produces exactly five output words.
- R6: A cycle with valid_i low adds no samples, emits nothing (valid_o low next cycle) and leaves the held samples in place, so later words continue the sequence unchanged.
- R7: data_o changes only in a cycle where valid_o is high. Otherwise it keeps the last emitted word.
- R8: Samples are signed two's complement, 16 bits wide by default (parameter SAMPLE_W), and pass through unmodified, including negative values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word carries five new samples |
| data_i | input | IN_LANES*SAMPLE_W (80) | Five input samples, lane 0 earliest |
| valid_o | output | 1 | data_o carries a fresh eight-sample word |
| data_o | output | OUT_LANES*SAMPLE_W (128) | Eight output samples, lane 0 oldest |

## Verification
The checker assumes that valid_i is a known 0 or 1 on every clock edge outside reset. It also assumes that rst_ni is low from time zero until the first edges have passed, so the fill count starts from a defined zero. The bench meets both assumptions. It drives valid_i and data_i only on the falling edge, and it holds reset low from the first instant before releasing it between edges. Sample values come from a running counter mapped into the full signed range, so every lane of every word is distinct. Any slip in order or any lost sample therefore shows up as a miscompare against the bench's own queue.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  parameter int unsigned GBX_IN_LANES  = 5;
  parameter int unsigned GBX_OUT_LANES = 8;
  parameter int unsigned GBX_SAMPLE_W  = 16;

  // merged span: worst-case leftover plus one input word
  function automatic int unsigned gbx_merge_depth(int unsigned in_l, int unsigned out_l);
    return in_l + out_l - 1;
  endfunction
endpackage

// File: rtl/gbx_merge.sv
module gbx_merge #(
  parameter int unsigned IN_LANES  = 5,
  parameter int unsigned OUT_LANES = 8,
  parameter int unsigned SAMPLE_W  = 16,
  localparam int unsigned HOLD     = OUT_LANES - 1,
  localparam int unsigned MRG      = IN_LANES + OUT_LANES - 1,
  localparam int unsigned CNT_W    = $clog2(MRG + 1)
) (
  input  logic [HOLD-1:0][SAMPLE_W-1:0]     hold_i,
  input  logic [CNT_W-1:0]                  fill_i,
  input  logic                              valid_i,
  input  logic [IN_LANES-1:0][SAMPLE_W-1:0] data_i,
  output logic [MRG-1:0][SAMPLE_W-1:0]      merged_o,
  output logic [CNT_W-1:0]                  total_o
);

  assign total_o = fill_i + (valid_i ? CNT_W'(IN_LANES) : '0);

  for (genvar g = 0; g < MRG; g++) begin : g_lane
    always_comb begin
      int off;
      off = g - int'(fill_i);
      merged_o[g] = '0;
      for (int k = 0; k < IN_LANES; k++) begin
        if (valid_i && off == k) merged_o[g] = data_i[k];
      end
      if (g < HOLD) begin
        if (off < 0) merged_o[g] = hold_i[(g < HOLD) ? g : 0];
      end
    end
  end

endmodule

// File: rtl/gbx_hold.sv
module gbx_hold #(
  parameter int unsigned IN_LANES  = 5,
  parameter int unsigned OUT_LANES = 8,
  parameter int unsigned SAMPLE_W  = 16,
  localparam int unsigned HOLD     = OUT_LANES - 1,
  localparam int unsigned MRG      = IN_LANES + OUT_LANES - 1,
  localparam int unsigned CNT_W    = $clog2(MRG + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [MRG-1:0][SAMPLE_W-1:0] merged_i,
  input  logic [CNT_W-1:0]             total_i,
  input  logic                         emit_i,
  output logic [HOLD-1:0][SAMPLE_W-1:0] hold_o,
  output logic [CNT_W-1:0]             fill_o
);

  logic [HOLD-1:0][SAMPLE_W-1:0] hold_d, hold_q;
  logic [CNT_W-1:0]              fill_d, fill_q;

  // after an emit the survivors slide down by one output word
  for (genvar g = 0; g < HOLD; g++) begin : g_slot
    if (g + OUT_LANES < MRG) begin : g_shift
      assign hold_d[g] = emit_i ? merged_i[g + OUT_LANES] : merged_i[g];
    end else begin : g_top
      assign hold_d[g] = emit_i ? '0 : merged_i[g];
    end
  end

  assign fill_d = emit_i ? (total_i - CNT_W'(OUT_LANES)) : total_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      fill_q <= '0;
    end else begin
      hold_q <= hold_d;
      fill_q <= fill_d;
    end
  end

  assign hold_o = hold_q;
  assign fill_o = fill_q;

endmodule

// File: rtl/gbx_out_reg.sv
module gbx_out_reg #(
  parameter int unsigned IN_LANES  = 5,
  parameter int unsigned OUT_LANES = 8,
  parameter int unsigned SAMPLE_W  = 16,
  localparam int unsigned MRG      = IN_LANES + OUT_LANES - 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [MRG-1:0][SAMPLE_W-1:0]       merged_i,
  input  logic                               emit_i,
  output logic                               valid_o,
  output logic [OUT_LANES-1:0][SAMPLE_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= emit_i;
      if (emit_i) data_o <= merged_i[OUT_LANES-1:0];
    end
  end

endmodule

// File: rtl/lane_gearbox.sv
module lane_gearbox #(
  parameter int unsigned IN_LANES  = gbx_pkg::GBX_IN_LANES,
  parameter int unsigned OUT_LANES = gbx_pkg::GBX_OUT_LANES,
  parameter int unsigned SAMPLE_W  = gbx_pkg::GBX_SAMPLE_W,
  localparam int unsigned HOLD     = OUT_LANES - 1,
  localparam int unsigned MRG      = gbx_pkg::gbx_merge_depth(IN_LANES, OUT_LANES),
  localparam int unsigned CNT_W    = $clog2(MRG + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [IN_LANES*SAMPLE_W-1:0]    data_i,
  output logic                            valid_o,
  output logic [OUT_LANES*SAMPLE_W-1:0]   data_o
);

  logic [IN_LANES-1:0][SAMPLE_W-1:0]  din;
  logic [OUT_LANES-1:0][SAMPLE_W-1:0] dout;
  logic [HOLD-1:0][SAMPLE_W-1:0]      hold_q;
  logic [MRG-1:0][SAMPLE_W-1:0]       merged;
  logic [CNT_W-1:0]                   fill_q;
  logic [CNT_W-1:0]                   total;
  logic                               emit;

  assign din    = data_i;
  assign data_o = dout;
  assign emit   = total >= CNT_W'(OUT_LANES);

  gbx_merge #(.IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES), .SAMPLE_W(SAMPLE_W)) u_merge (
    .hold_i   (hold_q),
    .fill_i   (fill_q),
    .valid_i  (valid_i),
    .data_i   (din),
    .merged_o (merged),
    .total_o  (total)
  );

  gbx_hold #(.IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES), .SAMPLE_W(SAMPLE_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .merged_i (merged),
    .total_i  (total),
    .emit_i   (emit),
    .hold_o   (hold_q),
    .fill_o   (fill_q)
  );

  gbx_out_reg #(.IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES), .SAMPLE_W(SAMPLE_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .merged_i (merged),
    .emit_i   (emit),
    .valid_o  (valid_o),
    .data_o   (dout)
  );

endmodule

// File: rtl/lane_gearbox_chk.sv
module lane_gearbox_chk #(
  parameter int unsigned IN_LANES  = 5,
  parameter int unsigned OUT_LANES = 8,
  parameter int unsigned SAMPLE_W  = 16,
  localparam int unsigned MRG      = IN_LANES + OUT_LANES - 1,
  localparam int unsigned CNT_W    = $clog2(MRG + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            valid_i,
  input logic                            valid_o,
  input logic [OUT_LANES*SAMPLE_W-1:0]   data_o,
  input logic [CNT_W-1:0]                fill_q
);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0));

  a_r2_full_word_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (int'(fill_q) + IN_LANES >= OUT_LANES)) |=> valid_o);

  a_r3_short_holds_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (int'(fill_q) + IN_LANES < OUT_LANES)) |=> !valid_o);

  a_r6_idle_no_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(fill_q)));

  a_r5_leftover_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_q) < OUT_LANES);

  a_r7_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

endmodule

bind lane_gearbox lane_gearbox_chk #(
  .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .fill_q  (fill_q)
);

// File: tb/lane_gearbox_bench.sv
module lane_gearbox_bench;
  localparam int IN_L  = 5;
  localparam int OUT_L = 8;
  localparam int W     = 16;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 valid_i = 1'b0;
  logic [IN_L*W-1:0]    data_i = '0;
  logic                 valid_o;
  logic [OUT_L*W-1:0]   data_o;

  int n_vec = 0;
  int n_bad = 0;
  int seq   = 0;
  bit done  = 1'b0;
  logic signed [W-1:0] model_q[$];
  logic [OUT_L*W-1:0]  last_out = '0;

  always #10 clk_i = ~clk_i;

  lane_gearbox u_lane_gearbox (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic signed [W-1:0] sample_of(int s);
    return W'(s * 7919 - 32000);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; drives, waits one rising edge, checks at next falling edge
  task automatic step(bit v, string req);
    logic [OUT_L*W-1:0] exp_d;
    bit exp_v;
    valid_i = v;
    for (int k = 0; k < IN_L; k++) begin
      data_i[k*W +: W] = v ? sample_of(seq + k) : W'(16'hdead + k);
    end
    if (v) begin
      for (int k = 0; k < IN_L; k++) model_q.push_back(sample_of(seq + k));
      seq += IN_L;
    end
    exp_v = model_q.size() >= OUT_L;
    exp_d = last_out;
    if (exp_v) for (int k = 0; k < OUT_L; k++) exp_d[k*W +: W] = model_q.pop_front();
    @(posedge clk_i);
    @(negedge clk_i);
    check({req, " valid"}, longint'(valid_o), longint'(exp_v));
    for (int k = 0; k < OUT_L; k++)
      check({req, exp_v ? " R4 lane" : " R7 hold"}, longint'(data_o[k*W +: W]),
            longint'(exp_d[k*W +: W]));
    last_out = exp_d;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    #1;
    check("R1 valid in reset", longint'(valid_o), 0);
    check("R1 data in reset", longint'(data_o == '0), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_q.delete();
    last_out = '0;
  endtask

  initial begin
    int emits;
    repeat (3) @(negedge clk_i);
    check("R1 valid after power-up reset", longint'(valid_o), 0);
    rst_ni = 1'b1;

    // R5: continuous cadence from empty, expected arithmetically
    for (int c = 1; c <= 24; c++) begin
      bit want;
      want = ((5 * c) / 8) > ((5 * (c - 1)) / 8);
      step(1'b1, "R2 R3 continuous");
      check("R5 cadence", longint'(valid_o), longint'(want));
    end
    check("R5 leftover zero after 3 periods", model_q.size(), 0);

    // R5: five words per eight-cycle period
    emits = 0;
    for (int c = 0; c < 8; c++) begin
      step(1'b1, "R5 period");
      emits += int'(valid_o);
    end
    check("R5 words per period", emits, 5);

    // R1: mid-stream reset drops leftovers
    step(1'b1, "R2 pre-reset");
    do_reset();
    step(1'b1, "R1 first word after reset");
    check("R1 no emit after reset", longint'(valid_o), 0);

    // R6: idle cycles hold the buffer
    for (int c = 0; c < 6; c++) step(1'b0, "R6 idle");
    step(1'b1, "R6 resume");
    check("R6 resume emits", longint'(valid_o), 1);

    // R2 R3 R4 R6 R8: every 8-cycle valid pattern
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int b = 0; b < 8; b++) step(p[b], "R2 R3 R6 R8 sweep");
      for (int b = 0; b < 4; b++) step(1'b1, "R4 R8 flush");
    end

    // R4 R6: long mixed run without reset
    do_reset();
    for (int c = 0; c < 600; c++) step(((c * 13) % 7) < 4, "R4 R6 mixed");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule